// File: doc/BRIEF.md
# Presettable CRC-CCITT Frame Check Generator

This block computes the 16-bit frame check sequence for the transmit side of a synchronous bit-oriented link. Data bits come in one at a time with a valid strobe. When the accumulate enable is set, each valid bit is folded into a running remainder over the polynomial x^16 + x^12 + x^5 + 1, with the most significant bit first. Upstream logic sends only the bits that lie between the opening and closing flags. Flag bits never reach this block.

The remainder is never preset on its own. It is loaded with all ones or all zeros, selected by a polarity input, in one of two ways:
- by a reset command, which takes effect only while the transmitter is enabled and idle;
- in auto-reset mode, by the frame-start pulse.

A send request moves the block into its output phase. For 16 cycles it shifts out the check bits, most significant first. The bits are complemented when the polarity input selected the all-ones preset. During this phase the remainder ignores every data input. A one-cycle done pulse follows the last check bit.

Top module: `crc_ccitt_gen`

## Requirements
- R1: After reset the remainder is zero, `crc_bit_valid_o` and `crc_done_o` are low. A send with `preset_ones_i`=0 issued straight after reset emits sixteen 0 bits.
- R2: The remainder follows x^16 + x^12 + x^5 + 1 (feedback mask 0x1021), with input bits taken MSB first. The nine ASCII bytes "123456789", each sent MSB first, give these transmitted words: 0xD64E after an all-ones preset, and 0x31C3 after an all-zeros preset.
- R3: A preset load writes 0xFFFF into the remainder when `preset_ones_i`=1 and 0x0000 when `preset_ones_i`=0.
- R4: `crc_reset_cmd_i` loads the preset only in a cycle where `tx_enabled_i`=1 and `tx_idle_i`=1. In any other cycle it is ignored.
- R5: While `crc_en_i`=0, valid data bits leave the remainder unchanged.
- R6: With `auto_reset_i`=1, a `frame_start_i` pulse loads the preset. With `auto_reset_i`=0, `frame_start_i` has no effect.
- R7: A `crc_send_i` seen while not sending starts the output phase. In the cycles after the request, `crc_bit_valid_o` is high for exactly 16 consecutive cycles. `crc_bit_o` carries the remainder MSB first, XORed with the `preset_ones_i` value sampled at the request. The remainder is left at zero afterwards.
- R8: During the output phase, data bits, reset commands, frame starts and further send requests are all ignored.
- R9: `crc_done_o` is high for exactly one cycle, the cycle after the 16th check bit.
- R10: When a preset load and a valid enabled data bit arrive in the same cycle, the load wins and the bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_ones_i | input | 1 | Preset polarity: 1 selects all ones, 0 selects all zeros |
| crc_en_i | input | 1 | Accumulate enable |
| tx_enabled_i | input | 1 | Transmitter enabled |
| tx_idle_i | input | 1 | Transmitter idle |
| crc_reset_cmd_i | input | 1 | Reset command pulse |
| auto_reset_i | input | 1 | Auto-reset mode select |
| frame_start_i | input | 1 | Frame start pulse |
| bit_i | input | 1 | Serial data bit |
| bit_valid_i | input | 1 | Data bit strobe |
| crc_send_i | input | 1 | Request to shift out the check bits |
| crc_bit_o | output | 1 | Serial check bit |
| crc_bit_valid_o | output | 1 | Check bit valid |
| crc_done_o | output | 1 | One-cycle pulse after the last check bit |

## Verification
The hardest situation to reach from the ports is a collision: a reset command, a frame start or a new send request arriving while the 16 check bits are still being shifted out. This matters most when the polarity input changes in the middle of the output phase. The stimulus covers it in two ways. First, directed sequences fire data bits, commands and polarity changes on every cycle of an output phase, then compare the emitted word against a known check value. Second, a long random phase uses a high strobe rate and frequent send requests, and a behavioural model is compared on every clock.

// File: rtl/crc_ccitt_pkg.sv
package crc_ccitt_pkg;
   localparam int unsigned CCITT_WIDTH = 16;
   localparam logic [CCITT_WIDTH-1:0] CCITT_MASK = 16'h1021;

   typedef enum logic {
      MODE_ACCUM = 1'b0,
      MODE_EMIT  = 1'b1
   } crc_mode_e;
endpackage

// File: rtl/crc_serial_step.sv
// One serial step of an MSB-first CRC remainder update.
module crc_serial_step #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] POLY = 16'h1021
) (
   input  logic [W-1:0] rem_i,
   input  logic         bit_i,
   output logic [W-1:0] rem_o
);
   logic fb;
   assign fb = bit_i ^ rem_i[W-1];

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign rem_o[i] = POLY[i] & fb;
      end else begin : g_mid
         assign rem_o[i] = rem_i[i-1] ^ (POLY[i] & fb);
      end
   end
endmodule

// File: rtl/crc_emit_ctrl.sv
// Sequencer for the check-bit output phase and the done pulse.
module crc_emit_ctrl
   import crc_ccitt_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic cmpl_i,
   output logic busy_o,
   output logic cmpl_o,
   output logic done_o
);
   localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   crc_mode_e        mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cmpl_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_ACCUM;
         cnt_q  <= '0;
         cmpl_q <= 1'b0;
         done_q <= 1'b0;
      end else if (mode_q == MODE_ACCUM) begin
         done_q <= 1'b0;
         if (start_i) begin
            mode_q <= MODE_EMIT;
            cnt_q  <= '0;
            cmpl_q <= cmpl_i;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST) begin
            mode_q <= MODE_ACCUM;
            done_q <= 1'b1;
         end
      end
   end

   assign busy_o = (mode_q == MODE_EMIT);
   assign cmpl_o = cmpl_q;
   assign done_o = done_q;
endmodule

// File: rtl/crc_ccitt_gen.sv
module crc_ccitt_gen
   import crc_ccitt_pkg::*;
#(
   parameter int unsigned W = CCITT_WIDTH,
   parameter logic [W-1:0] POLY = CCITT_MASK,
   parameter bit INVERT_ON_ONES = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic preset_ones_i,
   input  logic crc_en_i,
   input  logic tx_enabled_i,
   input  logic tx_idle_i,
   input  logic crc_reset_cmd_i,
   input  logic auto_reset_i,
   input  logic frame_start_i,
   input  logic bit_i,
   input  logic bit_valid_i,
   input  logic crc_send_i,
   output logic crc_bit_o,
   output logic crc_bit_valid_o,
   output logic crc_done_o
);
   if (W < 2) begin : g_bad_width
      $error("crc_ccitt_gen: W must be at least 2");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("crc_ccitt_gen: POLY needs its constant term set");
   end

   logic [W-1:0] rem_q;
   logic [W-1:0] rem_step;
   logic [W-1:0] preset_val;
   logic         busy;
   logic         cmpl;
   logic         load;
   logic         accum;

   assign preset_val = {W{preset_ones_i}};
   assign load  = !busy && ((crc_reset_cmd_i && tx_enabled_i && tx_idle_i)
                            || (auto_reset_i && frame_start_i));
   assign accum = !busy && bit_valid_i && crc_en_i;

   crc_serial_step #(.W(W), .POLY(POLY)) i_step (
      .rem_i (rem_q),
      .bit_i (bit_i),
      .rem_o (rem_step)
   );

   crc_emit_ctrl #(.W(W)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (crc_send_i),
      .cmpl_i  (preset_ones_i),
      .busy_o  (busy),
      .cmpl_o  (cmpl),
      .done_o  (crc_done_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (busy) begin
         rem_q <= {rem_q[W-2:0], 1'b0};
      end else if (load) begin
         rem_q <= preset_val;
      end else if (accum) begin
         rem_q <= rem_step;
      end
   end

   if (INVERT_ON_ONES) begin : g_inv
      assign crc_bit_o = busy & (rem_q[W-1] ^ cmpl);
   end else begin : g_plain
      logic unused_cmpl;
      assign unused_cmpl = cmpl;
      assign crc_bit_o = busy & rem_q[W-1];
   end

   assign crc_bit_valid_o = busy;
endmodule

// File: rtl/crc_ccitt_gen_chk.sv
module crc_ccitt_gen_chk #(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         preset_ones_i,
   input logic         crc_en_i,
   input logic         tx_enabled_i,
   input logic         tx_idle_i,
   input logic         crc_reset_cmd_i,
   input logic         auto_reset_i,
   input logic         frame_start_i,
   input logic         bit_valid_i,
   input logic         crc_send_i,
   input logic         crc_bit_valid_o,
   input logic         crc_done_o,
   input logic [W-1:0] rem_q
);
   p_preset_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_reset_cmd_i && tx_enabled_i && tx_idle_i && !crc_bit_valid_o)
      |=> (rem_q == {W{$past(preset_ones_i)}}));

   p_rem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!crc_bit_valid_o && !(bit_valid_i && crc_en_i)
       && !(crc_reset_cmd_i && tx_enabled_i && tx_idle_i)
       && !(auto_reset_i && frame_start_i))
      |=> $stable(rem_q));

   p_auto_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_reset_i && frame_start_i && !crc_bit_valid_o)
      |=> (rem_q == {W{$past(preset_ones_i)}}));

   p_run_begin_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_bit_valid_o) |-> $past(crc_send_i));

   p_run_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(crc_bit_valid_o) |-> crc_done_o);

   p_done_after_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done_o |-> (!crc_bit_valid_o && $past(crc_bit_valid_o)));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done_o |=> !crc_done_o);
endmodule

bind crc_ccitt_gen crc_ccitt_gen_chk #(.W(W)) i_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .preset_ones_i   (preset_ones_i),
   .crc_en_i        (crc_en_i),
   .tx_enabled_i    (tx_enabled_i),
   .tx_idle_i       (tx_idle_i),
   .crc_reset_cmd_i (crc_reset_cmd_i),
   .auto_reset_i    (auto_reset_i),
   .frame_start_i   (frame_start_i),
   .bit_valid_i     (bit_valid_i),
   .crc_send_i      (crc_send_i),
   .crc_bit_valid_o (crc_bit_valid_o),
   .crc_done_o      (crc_done_o),
   .rem_q           (rem_q)
);

// File: tb/test_crc_ccitt_gen.sv
`timescale 1ns/1ps
module test_crc_ccitt_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic preset_ones_i = 1'b0, crc_en_i = 1'b0, tx_enabled_i = 1'b0, tx_idle_i = 1'b0;
   logic crc_reset_cmd_i = 1'b0, auto_reset_i = 1'b0, frame_start_i = 1'b0;
   logic bit_i = 1'b0, bit_valid_i = 1'b0, crc_send_i = 1'b0;
   logic crc_bit_o, crc_bit_valid_o, crc_done_o;

   int vectors = 0;
   int errors  = 0;

   always #10 clk = ~clk;

   crc_ccitt_gen i_crc_ccitt_gen (
      .clk(clk), .rst_n(rst_n), .preset_ones_i(preset_ones_i), .crc_en_i(crc_en_i),
      .tx_enabled_i(tx_enabled_i), .tx_idle_i(tx_idle_i), .crc_reset_cmd_i(crc_reset_cmd_i),
      .auto_reset_i(auto_reset_i), .frame_start_i(frame_start_i), .bit_i(bit_i),
      .bit_valid_i(bit_valid_i), .crc_send_i(crc_send_i), .crc_bit_o(crc_bit_o),
      .crc_bit_valid_o(crc_bit_valid_o), .crc_done_o(crc_done_o)
   );

   // behavioural reference model
   logic [15:0] m_rem = '0;
   logic [15:0] m_snap = '0;
   bit  m_busy = 0, m_cmpl = 0, m_done = 0;
   int  m_idx = 0;

   function automatic logic [15:0] fold(input logic [15:0] r, input logic b);
      logic top;
      top = r[15];
      r = r << 1;
      if (top ^ b) r = r ^ 16'h1021;
      return r;
   endfunction

   always @(posedge clk) begin
      bit nd;
      nd = 0;
      if (!rst_n) begin
         m_rem = '0; m_busy = 0; m_idx = 0; m_cmpl = 0;
      end else if (m_busy) begin
         m_idx = m_idx + 1;
         if (m_idx == 16) begin m_busy = 0; nd = 1; m_rem = '0; end
      end else begin
         if ((crc_reset_cmd_i && tx_enabled_i && tx_idle_i) || (auto_reset_i && frame_start_i))
            m_rem = preset_ones_i ? 16'hFFFF : 16'h0000;
         else if (bit_valid_i && crc_en_i)
            m_rem = fold(m_rem, bit_i);
         if (crc_send_i) begin
            m_busy = 1; m_idx = 0; m_snap = m_rem; m_cmpl = preset_ones_i;
         end
      end
      m_done = nd;
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R7 valid", {15'd0, crc_bit_valid_o}, {15'd0, m_busy});
         if (m_busy) chk("R7 bit", {15'd0, crc_bit_o}, {15'd0, m_snap[15-m_idx] ^ m_cmpl});
         chk("R9 done", {15'd0, crc_done_o}, {15'd0, m_done});
      end
   end

   initial begin
      #(20ns * 200000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   task automatic cyc(); @(negedge clk); endtask

   task automatic cmd_load(input bit pre);
      preset_ones_i = pre; tx_enabled_i = 1; tx_idle_i = 1; crc_reset_cmd_i = 1;
      cyc();
      crc_reset_cmd_i = 0;
   endtask

   task automatic feed_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         bit_valid_i = 1; bit_i = b[i]; cyc();
      end
      bit_valid_i = 0;
   endtask

   task automatic feed_check_string();
      crc_en_i = 1;
      for (int k = 1; k <= 9; k++) feed_byte(8'h30 + 8'(k));
   endtask

   task automatic get_crc(input bit pre, input bit disturb, output logic [15:0] w);
      preset_ones_i = pre; crc_send_i = 1;
      cyc();
      crc_send_i = 0;
      w = '0;
      for (int i = 0; i < 16; i++) begin
         if (disturb) begin
            bit_valid_i = 1; bit_i = i[0]; crc_en_i = 1; crc_reset_cmd_i = 1;
            tx_enabled_i = 1; tx_idle_i = 1; auto_reset_i = 1; frame_start_i = 1;
            crc_send_i = 1; preset_ones_i = ~pre;
         end
         w = {w[14:0], crc_bit_o};
         cyc();
      end
      bit_valid_i = 0; crc_reset_cmd_i = 0; frame_start_i = 0; crc_send_i = 0;
      auto_reset_i = 0; preset_ones_i = pre;
      chk("R9 done after 16th bit", {15'd0, crc_done_o}, 16'd1);
   endtask

   initial begin
      logic [15:0] w;
      repeat (3) cyc();
      chk("R1 valid after reset", {15'd0, crc_bit_valid_o}, 16'd0);
      chk("R1 done after reset", {15'd0, crc_done_o}, 16'd0);
      rst_n = 1;
      cyc();
      get_crc(0, 0, w);
      chk("R1 remainder zero", w, 16'h0000);

      // R2/R3 known check values
      cmd_load(1); feed_check_string(); get_crc(1, 0, w);
      chk("R2 R3 ones preset check value", w, 16'hD64E);
      cmd_load(0); feed_check_string(); get_crc(0, 0, w);
      chk("R2 R3 zeros preset check value", w, 16'h31C3);

      // R4 command ignored unless enabled and idle
      cmd_load(1);
      preset_ones_i = 0; crc_reset_cmd_i = 1; tx_enabled_i = 1; tx_idle_i = 0; cyc();
      tx_enabled_i = 0; tx_idle_i = 1; cyc();
      crc_reset_cmd_i = 0;
      get_crc(1, 0, w);
      chk("R4 command ignored when busy or disabled", w, 16'h0000);

      // R5 enable low blocks accumulation
      cmd_load(0); crc_en_i = 0;
      feed_byte(8'hA5); feed_byte(8'hFF);
      get_crc(0, 0, w);
      chk("R5 disabled bits ignored", w, 16'h0000);

      // R6 auto mode
      cmd_load(0); crc_en_i = 1; feed_byte(8'h5A);
      auto_reset_i = 1; preset_ones_i = 1; frame_start_i = 1; cyc();
      frame_start_i = 0; auto_reset_i = 0;
      feed_check_string(); get_crc(1, 0, w);
      chk("R6 auto preset at frame start", w, 16'hD64E);
      cmd_load(0);
      preset_ones_i = 1; frame_start_i = 1; cyc(); frame_start_i = 0;
      get_crc(1, 0, w);
      chk("R6 frame start ignored without auto", w, 16'hFFFF);

      // R8 everything disturbed during the output phase
      cmd_load(1); feed_check_string(); get_crc(1, 1, w);
      chk("R8 output phase ignores inputs", w, 16'hD64E);
      crc_en_i = 0; tx_enabled_i = 0;
      repeat (2) cyc();

      // R10 load beats simultaneous data bit
      cmd_load(1); crc_en_i = 1;
      preset_ones_i = 0; crc_reset_cmd_i = 1; tx_enabled_i = 1; tx_idle_i = 1;
      bit_valid_i = 1; bit_i = 1; cyc();
      crc_reset_cmd_i = 0; bit_valid_i = 0;
      get_crc(0, 0, w);
      chk("R10 load wins over data bit", w, 16'h0000);

      // random phase, model compared every clock
      for (int n = 0; n < 3000; n++) begin
         bit_valid_i     = ($urandom_range(0, 3) != 0);
         bit_i           = 1'($urandom);
         crc_en_i        = ($urandom_range(0, 5) != 0);
         preset_ones_i   = 1'($urandom);
         tx_enabled_i    = 1'($urandom);
         tx_idle_i       = 1'($urandom);
         crc_reset_cmd_i = ($urandom_range(0, 15) == 0);
         auto_reset_i    = 1'($urandom);
         frame_start_i   = ($urandom_range(0, 15) == 0);
         crc_send_i      = ($urandom_range(0, 20) == 0);
         cyc();
      end
      bit_valid_i = 0; crc_reset_cmd_i = 0; frame_start_i = 0; crc_send_i = 0;
      repeat (20) cyc();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule